// File: doc/BRIEF.md
# GPIO Interrupt Cause Aggregator

This block turns 32 asynchronous GPIO lines into four interrupt requests for a main interrupt controller. Each line is brought into the clock domain by a two-flop synchroniser. A per-line polarity bit then either passes it through or inverts it. The result, called the adjusted input, drives two paths. The level path gates it with a level mask and keeps no state. The edge path latches every 0-to-1 step of the adjusted input into a sticky edge-cause bit, which an edge mask then gates.

The two paths are ORed for each line. The per-line causes of each group of eight consecutive lines are then ORed into one summary output. Software uses a small word-addressed register port to read the adjusted inputs, to program polarity and both masks, and to clear edge causes. Polarity 0 gives active-high or rising-edge sensing. Polarity 1 gives active-low or falling-edge sensing. Flipping a polarity bit on a steady line produces a step in the adjusted input, and that step is caught as an edge. Driver software can therefore follow both edges of a line by toggling polarity after each event.

Top module: `gpio_irq_agg`

## Requirements
- R1: After reset the polarity, level mask, edge mask and edge-cause registers are all zero, every summary output is 0, and every register reads 0 while the lines are low.
- R2: Reading offset 0x00 returns, for each line, the synchronised line level XOR its polarity bit. A line change driven before clock edge k is visible from edge k+1. Writes to 0x00 have no effect.
- R3: The level cause of line i is adjusted input i AND level mask bit i. It holds no memory: it drops once the adjusted input drops.
- R4: Edge-cause bit i is set when adjusted input i is 1 and was 0 one cycle earlier. With polarity 0 this is a rising line edge, and with polarity 1 a falling one. The bit stays set until it is cleared.
- R5: A write to offset 0x08 clears each edge-cause bit whose data bit is 0 and leaves set each bit whose data bit is 1. When a new edge and a clear hit the same bit in one cycle, the bit ends up set.
- R6: Writing a polarity bit that changes the adjusted input of a steady line from 0 to 1 latches an edge cause for that line.
- R7: The cause of line i is (adjusted input AND level mask) OR (edge cause AND edge mask). Summary output g is the OR of the causes of lines 8g to 8g+7.
- R8: Register offsets are: polarity 0x04, edge cause 0x08, edge mask 0x0C, level mask 0x10. A read returns its data on the clock edge that samples it, and the value holds until the next read. Reads of any other offset return 0.
- R9: Polarity, edge mask and level mask take the written value on the clock edge of the write and read it back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| lineIn | input | 32 | Asynchronous GPIO line levels |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 5 | Byte offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| irqGroup | output | 4 | Summary interrupt for each group of eight lines |

## Verification
The bench builds the block with its defaults: 32 lines, groups of eight and two synchroniser stages. With these values all four summary outputs are exercised, and the group boundaries at lines 7/8, 15/16 and 23/24 can be reached. Random line toggles, mask and polarity writes and partial edge-cause clears run against a cycle-accurate model of the synchroniser, edge latch and read register. Directed sequences cover the cases random stimulus seldom hits: a polarity step on a steady line, a falling edge with inverted polarity, and an edge arriving in the same cycle as its clear.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int OFF_DIN    = 'h00;
  localparam int OFF_POL    = 'h04;
  localparam int OFF_ECAUSE = 'h08;
  localparam int OFF_EMASK  = 'h0C;
  localparam int OFF_LMASK  = 'h10;

  typedef enum logic [2:0] {
    SEL_DIN,
    SEL_POL,
    SEL_ECAUSE,
    SEL_EMASK,
    SEL_LMASK,
    SEL_NONE
  } rdSel_e;

  typedef struct packed {
    logic   wrPol;
    logic   wrEdgeCause;
    logic   wrEdgeMask;
    logic   wrLevelMask;
    logic   rdEn;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-2:0], asyncIn};
  end

  assign syncOut = pipe[STAGES-1];
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobe_t        strb
);
  always_comb begin
    strb = '0;
    strb.rdSel = SEL_NONE;
    strb.rdEn  = rdEn;
    if (wrEn) begin
      strb.wrPol       = (addr == ADDR_W'(OFF_POL));
      strb.wrEdgeCause = (addr == ADDR_W'(OFF_ECAUSE));
      strb.wrEdgeMask  = (addr == ADDR_W'(OFF_EMASK));
      strb.wrLevelMask = (addr == ADDR_W'(OFF_LMASK));
    end
    if      (addr == ADDR_W'(OFF_DIN))    strb.rdSel = SEL_DIN;
    else if (addr == ADDR_W'(OFF_POL))    strb.rdSel = SEL_POL;
    else if (addr == ADDR_W'(OFF_ECAUSE)) strb.rdSel = SEL_ECAUSE;
    else if (addr == ADDR_W'(OFF_EMASK))  strb.rdSel = SEL_EMASK;
    else if (addr == ADDR_W'(OFF_LMASK))  strb.rdSel = SEL_LMASK;
  end
endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int GROUP_SIZE  = 8,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_GROUPS = NUM_LINES / GROUP_SIZE
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LINES-1:0]  lineIn,
  input  regStrobe_t            strb,
  input  logic [NUM_LINES-1:0]  wrData,
  output logic [NUM_LINES-1:0]  rdData,
  output logic [NUM_GROUPS-1:0] irqGroup
);
  logic [NUM_LINES-1:0] syncLine, adjIn, prevAdj, riseHit;
  logic [NUM_LINES-1:0] polarity, edgeCause, edgeMask, levelMask;
  logic [NUM_LINES-1:0] lineCause, rdNext;

  gpio_irq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (lineIn),
    .syncOut (syncLine)
  );

  assign adjIn   = syncLine ^ polarity;
  assign riseHit = adjIn & ~prevAdj;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevAdj   <= '0;
      polarity  <= '0;
      edgeCause <= '0;
      edgeMask  <= '0;
      levelMask <= '0;
    end else begin
      prevAdj <= adjIn;
      if (strb.wrPol)       polarity  <= wrData;
      if (strb.wrEdgeMask)  edgeMask  <= wrData;
      if (strb.wrLevelMask) levelMask <= wrData;
      if (strb.wrEdgeCause) edgeCause <= (edgeCause & wrData) | riseHit;
      else                  edgeCause <= edgeCause | riseHit;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_DIN:    rdNext = adjIn;
      SEL_POL:    rdNext = polarity;
      SEL_ECAUSE: rdNext = edgeCause;
      SEL_EMASK:  rdNext = edgeMask;
      SEL_LMASK:  rdNext = levelMask;
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdEn) rdData <= rdNext;
  end

  assign lineCause = (adjIn & levelMask) | (edgeCause & edgeMask);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    assign irqGroup[g] = |lineCause[g*GROUP_SIZE +: GROUP_SIZE];
  end

  // R1: the first active cycle after reset starts with everything cleared
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (edgeCause == '0 && edgeMask == '0 && levelMask == '0));

  // R4: a detected step is latched on the next edge, whatever the write
  assert_edge_latch_R4: assert property (@(posedge clk) disable iff (!rstN)
    (riseHit != '0) |=> ((edgeCause & $past(riseHit)) == $past(riseHit)));

  // R4: without a clear write no edge-cause bit falls
  assert_edge_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEdgeCause |=> ((edgeCause & $past(edgeCause)) == $past(edgeCause)));

  // R5: zero data bits clear unless an edge arrives in the same cycle
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEdgeCause |=> ((edgeCause & ~$past(wrData) & ~$past(riseHit)) == '0));

  // R3: an unmasked active level always raises some summary output
  assert_level_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((adjIn & levelMask) != '0) |-> (irqGroup != '0));

  // R7: no unmasked cause means all summary outputs low
  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((adjIn & levelMask) == '0 && (edgeCause & edgeMask) == '0) |-> (irqGroup == '0));

  // R8: read data holds between reads
  assert_read_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> $stable(rdData));
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
  import gpio_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] lineIn,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [4:0]  addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic [3:0]  irqGroup
);
  localparam int NUM_LINES  = 32;
  localparam int GROUP_SIZE = 8;
  localparam int ADDR_W     = 5;

  regStrobe_t strb;

  gpio_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .strb (strb)
  );

  gpio_irq_datapath #(
    .NUM_LINES   (NUM_LINES),
    .GROUP_SIZE  (GROUP_SIZE),
    .SYNC_STAGES (2)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .lineIn   (lineIn),
    .strb     (strb),
    .wrData   (wrData),
    .rdData   (rdData),
    .irqGroup (irqGroup)
  );
endmodule

// File: tb/gpio_irq_agg_tb.sv
module gpio_irq_agg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lineIn = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  irqGroup;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  // bench model state
  logic [31:0] mS1 = '0, mS2 = '0, mPrev = '0, mPol = '0;
  logic [31:0] mEc = '0, mEm = '0, mLm = '0, mRd = '0;

  gpio_irq_agg u_dut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqGroup(irqGroup)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] modelRead(input logic [4:0] a);
    case (a)
      5'h00:   return mS2 ^ mPol;
      5'h04:   return mPol;
      5'h08:   return mEc;
      5'h0C:   return mEm;
      5'h10:   return mLm;
      default: return '0;
    endcase
  endfunction

  function automatic logic [3:0] modelGroups();
    logic [31:0] cause;
    logic [3:0]  g;
    cause = ((mS2 ^ mPol) & mLm) | (mEc & mEm);
    for (int i = 0; i < 4; i++) g[i] = |cause[i*8 +: 8];
    return g;
  endfunction

  function automatic string readTag(input logic [4:0] a);
    case (a)
      5'h00:   return "R2";
      5'h08:   return "R4/R5";
      5'h04, 5'h0C, 5'h10: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic tick();
    logic [31:0] adj, rise;
    string tag;
    @(posedge clk);
    adj  = mS2 ^ mPol;
    rise = adj & ~mPrev;
    tag  = rdEn ? readTag(addr) : "R8";
    if (rdEn) mRd = modelRead(addr);
    mPrev = adj;
    mS2 = mS1;
    mS1 = lineIn;
    if (wrEn && addr == 5'h08) mEc = (mEc & wrData) | rise;
    else                       mEc = mEc | rise;
    if (wrEn && addr == 5'h04) mPol = wrData;
    if (wrEn && addr == 5'h0C) mEm = wrData;
    if (wrEn && addr == 5'h10) mLm = wrData;
    @(negedge clk);
    check(tag, rdData, mRd);
    check("R7", {28'b0, irqGroup}, {28'b0, modelGroups()});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic doWrite(input logic [4:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [4:0] a);
    rdEn = 1'b1; addr = a;
    tick();
    rdEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    while (cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
    finishRun();
  end

  initial begin
    logic [4:0] addrSet [5];
    addrSet = '{5'h00, 5'h04, 5'h08, 5'h0C, 5'h10};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    check("R1 irq", {28'b0, irqGroup}, 32'h0);
    foreach (addrSet[k]) begin
      doRead(addrSet[k]);
      check("R1 read", rdData, 32'h0);
    end

    // R3: level path, no memory
    doWrite(5'h10, 32'h0000_0008);
    lineIn[3] = 1'b1;
    idle(2);
    check("R3 level high", {28'b0, irqGroup}, 32'h1);
    lineIn[3] = 1'b0;
    idle(2);
    check("R3 level dropped", {28'b0, irqGroup}, 32'h0);
    doRead(5'h08);
    check("R4 sticky rise", rdData, 32'h0000_0008);
    doWrite(5'h08, ~32'h0000_0008);
    doRead(5'h08);
    check("R5 cleared", rdData, 32'h0);
    doWrite(5'h10, 32'h0);

    // R6: polarity step on a steady low line is an edge
    doWrite(5'h0C, 32'h0000_0200);
    doWrite(5'h04, 32'h0000_0200);
    idle(1);
    check("R6 polarity step", {28'b0, irqGroup}, 32'h2);
    doWrite(5'h08, ~32'h0000_0200);
    check("R5 clear no new edge", {28'b0, irqGroup}, 32'h0);

    // R4: with polarity 1 a rising line is ignored, a falling one latches
    lineIn[9] = 1'b1;
    idle(3);
    check("R4 rise ignored", {28'b0, irqGroup}, 32'h0);
    lineIn[9] = 1'b0;
    idle(3);
    check("R4 fall latched", {28'b0, irqGroup}, 32'h2);
    doWrite(5'h08, ~32'h0000_0200);

    // R5: edge and clear in the same cycle, edge wins
    lineIn[9] = 1'b1;
    idle(3);
    lineIn[9] = 1'b0;
    idle(2);
    doWrite(5'h08, ~32'h0000_0200);
    check("R5 edge wins", {28'b0, irqGroup}, 32'h2);
    doRead(5'h08);
    check("R5 edge wins read", rdData & 32'h0000_0200, 32'h0000_0200);

    // R2: data-in ignores writes
    lineIn = 32'hA5A5_0F0F;
    idle(3);
    doWrite(5'h00, 32'hFFFF_FFFF);
    doRead(5'h00);
    check("R2 read-only", rdData, 32'hA5A5_0F0F ^ 32'h0000_0200);

    // R8: unmapped offset reads zero
    doRead(5'h14);
    check("R8 unmapped", rdData, 32'h0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int op;
      if ($urandom % 3 == 0) lineIn[$urandom % 32] ^= 1'b1;
      op = $urandom % 10;
      if (op < 3) begin
        logic [4:0] a;
        logic [31:0] d;
        a = addrSet[$urandom % 5];
        d = $urandom;
        if (a == 5'h08) d = ~(32'h1 << ($urandom % 32));
        wrEn = 1'b1; addr = a; wrData = d;
      end else if (op < 7) begin
        rdEn = 1'b1;
        addr = ($urandom % 4 == 0) ? 5'($urandom) : addrSet[$urandom % 5];
      end
      tick();
      wrEn = 1'b0;
      rdEn = 1'b0;
    end

    finishRun();
  end
endmodule